// File: doc/BRIEF.md
# Status Flag Interrupt and DMA Request Steering

This block keeps two status flags for a serial port, one that says the transmit data register is empty and one that says the receive data register is full. Each flag follows a level condition from the datapath: it sets while the condition holds. The flag is then steered to one of two places. It can drive a CPU interrupt line, or it can drive a DMA request line that a DMA engine services.

Each flag has an enable bit and a DMA-select bit. DMA mode is active when both bits are 1. In interrupt mode, software clears a flag with a two-step access. It first reads the status register while the flag is set. For the receive flag it then reads the data register, and for the transmit flag it then writes the data register.

In DMA mode that two-step access has no effect. The request stays high until the DMA engine returns a done pulse. The done pulse clears both the flag and the request. If the datapath condition is still present, the flag sets again and a fresh request follows on the next cycle.

Top module: `flag_dma_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both flags, both interrupt lines and both request lines are 0 after that edge.
- R2: A flag whose condition input is 1 at a clock edge reads 1 after that edge, unless a clear takes effect at the same edge.
- R3: With DMA-select 0, the interrupt line of a flag equals the flag ANDed with its enable bit, and its request line is 0.
- R4: In interrupt mode, the receive flag clears at the edge of a data read only if an earlier status read saw the flag set. A data read with no such prior status read leaves the flag set.
- R5: In interrupt mode, the transmit flag clears at the edge of a data write that follows a status read which saw the flag set.
- R6: With enable 1 and DMA-select 1, the request line equals the flag and the interrupt line is 0. The interrupt line and the request line of a flag are never 1 together.
- R7: In DMA mode, the status-read and data-access sequence does not clear the flag.
- R8: In DMA mode, a done pulse clears the flag and the request at that edge. If the condition is still 1, the flag and the request return one edge later. A done pulse has priority over a set at the same edge.
- R9: In interrupt mode, done pulses have no effect on the flag.
- R10: With enable 0 and DMA-select 1, the flag still sets, but both the interrupt line and the request line stay 0.
- R11: A status read and a data access in the same cycle do not clear the flag. That status read arms the clear for a later data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_empty_i | input | 1 | Level: transmit data register is empty |
| rx_full_i | input | 1 | Level: receive data register holds data |
| tx_ie_i | input | 1 | Transmit flag enable |
| tx_dsel_i | input | 1 | Transmit flag DMA select |
| rx_ie_i | input | 1 | Receive flag enable |
| rx_dsel_i | input | 1 | Receive flag DMA select |
| stat_rd_i | input | 1 | Strobe: status register read |
| data_rd_i | input | 1 | Strobe: data register read |
| data_wr_i | input | 1 | Strobe: data register write |
| tx_done_i | input | 1 | DMA done pulse for the transmit request |
| rx_done_i | input | 1 | DMA done pulse for the receive request |
| tx_flag_o | output | 1 | Transmit-empty flag |
| rx_flag_o | output | 1 | Receive-full flag |
| tx_irq_o | output | 1 | Transmit interrupt line |
| rx_irq_o | output | 1 | Receive interrupt line |
| tx_dreq_o | output | 1 | Transmit DMA request |
| rx_dreq_o | output | 1 | Receive DMA request |

## Verification
Two collisions are forced on purpose. The first is a DMA done pulse arriving while the receive condition is still 1. The bench expects the flag and the request to read 0 for exactly one cycle and then return high. The second is a status read and a data read strobed in the same cycle. The bench expects the flag to survive that cycle and to clear only on the next lone data read. The vector table drives each collision, and the outputs are compared half a period after the edge.

// File: rtl/flag_dma_pkg.sv
// Shared constants and channel numbering for the flag steering block.
// Assumes channel 0 is transmit-empty and channel 1 is receive-full.
package flag_dma_pkg;
    localparam int NCH = 2;

    typedef enum logic {
        CH_TX = 1'b0,
        CH_RX = 1'b1
    } ch_e;
endpackage

// File: rtl/fdc_flag_cell.sv
// One status flag with its two-step software clear and its DMA done clear.
// Assumes cond_i is a level from the datapath and that the strobes last one cycle.
// A clear at an edge wins over a set at the same edge.
module fdc_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic dma_mode_i,
    input  logic stat_rd_i,
    input  logic acc_i,
    input  logic done_i,
    output logic flag_o
);
    logic flag_q;
    logic armed_q;
    logic sw_clr;
    logic dma_clr;
    logic clr;

    // Clear sources: armed software access in interrupt mode, done pulse in DMA mode.
    always_comb begin
        sw_clr  = armed_q & acc_i & ~dma_mode_i;
        dma_clr = done_i & dma_mode_i;
        clr     = sw_clr | dma_clr;
    end

    // Flag register: clear has priority, otherwise the level condition sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (clr) begin
            flag_q <= 1'b0;
        end else if (cond_i) begin
            flag_q <= 1'b1;
        end
    end

    // Arming register: a status read that sees the flag set arms the next data access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (clr) begin
            armed_q <= 1'b0;
        end else if (acc_i) begin
            armed_q <= stat_rd_i & flag_q;
        end else if (stat_rd_i && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && cond_i && !done_i) |=> flag_q);
    assert_sw_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode_i && flag_q && !done_i) |=> flag_q);
    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode_i && done_i) |=> !flag_q);
    assert_done_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_mode_i && flag_q && !acc_i) |=> flag_q);
    assert_arm_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_q |-> !armed_q);
endmodule

// File: rtl/fdc_route.sv
// Steers one flag to its interrupt line or its DMA request line.
// Assumes DMA mode means enable and DMA-select are both 1.
// DMA-select 1 always holds the interrupt line low.
module fdc_route (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    input  logic ie_i,
    input  logic dsel_i,
    output logic dma_mode_o,
    output logic irq_o,
    output logic dreq_o
);
    // Output steering: the two destinations are mutually exclusive.
    always_comb begin
        dma_mode_o = ie_i & dsel_i;
        irq_o      = flag_i & ie_i & ~dsel_i;
        dreq_o     = flag_i & dma_mode_o;
    end

    assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && dreq_o));
    assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_i);
    assert_dreq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_o |-> flag_i);
endmodule

// File: rtl/flag_dma_ctrl.sv
// Top: two status flags (transmit-empty, receive-full), each steered to
// an interrupt or a DMA request. Assumes single-cycle strobes and done pulses.
// The transmit flag's clearing access is a data write; the receive flag's is a data read.
module flag_dma_ctrl
    import flag_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty_i,
    input  logic rx_full_i,
    input  logic tx_ie_i,
    input  logic tx_dsel_i,
    input  logic rx_ie_i,
    input  logic rx_dsel_i,
    input  logic stat_rd_i,
    input  logic data_rd_i,
    input  logic data_wr_i,
    input  logic tx_done_i,
    input  logic rx_done_i,
    output logic tx_flag_o,
    output logic rx_flag_o,
    output logic tx_irq_o,
    output logic rx_irq_o,
    output logic tx_dreq_o,
    output logic rx_dreq_o
);
    logic [NCH-1:0] cond;
    logic [NCH-1:0] ie;
    logic [NCH-1:0] dsel;
    logic [NCH-1:0] done;
    logic [NCH-1:0] flag;
    logic [NCH-1:0] dma_mode;
    logic [NCH-1:0] irq;
    logic [NCH-1:0] dreq;

    // Gather per-channel inputs into vectors indexed by channel.
    always_comb begin
        cond[CH_TX] = tx_empty_i;
        cond[CH_RX] = rx_full_i;
        ie[CH_TX]   = tx_ie_i;
        ie[CH_RX]   = rx_ie_i;
        dsel[CH_TX] = tx_dsel_i;
        dsel[CH_RX] = rx_dsel_i;
        done[CH_TX] = tx_done_i;
        done[CH_RX] = rx_done_i;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic acc;
        if (i == int'(CH_TX)) begin : g_acc_wr
            assign acc = data_wr_i;
        end else begin : g_acc_rd
            assign acc = data_rd_i;
        end

        fdc_flag_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .cond_i     (cond[i]),
            .dma_mode_i (dma_mode[i]),
            .stat_rd_i  (stat_rd_i),
            .acc_i      (acc),
            .done_i     (done[i]),
            .flag_o     (flag[i])
        );

        fdc_route u_route (
            .clk        (clk),
            .rst_n      (rst_n),
            .flag_i     (flag[i]),
            .ie_i       (ie[i]),
            .dsel_i     (dsel[i]),
            .dma_mode_o (dma_mode[i]),
            .irq_o      (irq[i]),
            .dreq_o     (dreq[i])
        );
    end

    assign tx_flag_o = flag[CH_TX];
    assign rx_flag_o = flag[CH_RX];
    assign tx_irq_o  = irq[CH_TX];
    assign rx_irq_o  = irq[CH_RX];
    assign tx_dreq_o = dreq[CH_TX];
    assign rx_dreq_o = dreq[CH_RX];
endmodule

// File: tb/sim_flag_dma_ctrl.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed reset and done tests.
module sim_flag_dma_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic te = 0, rf = 0, tie = 0, tds = 0, rie = 0, rds = 0;
    logic srd = 0, drd = 0, dwr = 0, tdn = 0, rdn = 0;
    logic tf, rfl, ti, ri, tq, rq;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    flag_dma_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_empty_i(te), .rx_full_i(rf),
        .tx_ie_i(tie), .tx_dsel_i(tds), .rx_ie_i(rie), .rx_dsel_i(rds),
        .stat_rd_i(srd), .data_rd_i(drd), .data_wr_i(dwr),
        .tx_done_i(tdn), .rx_done_i(rdn),
        .tx_flag_o(tf), .rx_flag_o(rfl), .tx_irq_o(ti), .rx_irq_o(ri),
        .tx_dreq_o(tq), .rx_dreq_o(rq)
    );

    // Row: {req, stim, expected}. stim bits 10..0 = te rf tie tds rie rds srd drd dwr tdn rdn.
    // expected bits 5..0 = tx_flag rx_flag tx_irq rx_irq tx_dreq rx_dreq.
    localparam int NV = 22;
    localparam logic [20:0] VEC [NV] = '{
        {4'd2,  11'b10100000000, 6'b101000}, // R2 tx sets, R3 irq
        {4'd5,  11'b00100010000, 6'b101000}, // R5 status read arms
        {4'd5,  11'b00100000100, 6'b000000}, // R5 data write clears
        {4'd3,  11'b01001000000, 6'b010100}, // R3 rx irq
        {4'd4,  11'b01001001000, 6'b010100}, // R4 unarmed read ignored
        {4'd4,  11'b00001010000, 6'b010100}, // R4 status read arms
        {4'd4,  11'b00001001000, 6'b000000}, // R4 data read clears
        {4'd2,  11'b01001000000, 6'b010100}, // R2 rx sets again
        {4'd11, 11'b00001011000, 6'b010100}, // R11 same-cycle pair keeps flag
        {4'd11, 11'b00001001000, 6'b000000}, // R11 next read clears
        {4'd6,  11'b01001100000, 6'b010001}, // R6 rx DMA request
        {4'd7,  11'b01001110000, 6'b010001}, // R7 status read in DMA
        {4'd7,  11'b01001101000, 6'b010001}, // R7 data read ignored
        {4'd8,  11'b01001100001, 6'b000000}, // R8 done with condition high
        {4'd8,  11'b01001100000, 6'b010001}, // R8 request returns
        {4'd8,  11'b00001100001, 6'b000000}, // R8 done, condition gone
        {4'd8,  11'b00001100000, 6'b000000}, // R8 stays clear
        {4'd2,  11'b10100000000, 6'b101000}, // R2 tx sets
        {4'd9,  11'b00100000010, 6'b101000}, // R9 done ignored in irq mode
        {4'd10, 11'b00010000000, 6'b100000}, // R10 ie 0, dsel 1
        {4'd6,  11'b00110000000, 6'b100010}, // R6 tx DMA request
        {4'd8,  11'b00110000010, 6'b000000}  // R8 tx done clears
    };

    task automatic drive(input logic [10:0] s);
        {te, rf, tie, tds, rie, rds, srd, drd, dwr, tdn, rdn} = s;
    endtask

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {tf, rfl, ti, ri, tq, rq};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b, expected %b", req, act, exp);
        end
    endtask

    // Drive on the falling edge, let one rising edge pass, sample on the next falling edge.
    task automatic step(input logic [10:0] s, input string req, input logic [5:0] exp);
        drive(s);
        @(posedge clk);
        @(negedge clk);
        check(req, exp);
    endtask

    initial begin : watchdog
        while (cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: cycles %0d, expected under 5000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R1 reset state, with conditions driven high during reset.
        drive(11'b11101000000);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", 6'b000000);
        drive(11'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 6'b000000);

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][16:6], $sformatf("R%0d row %0d", VEC[k][20:17], k), VEC[k][5:0]);
        end

        // R1 mid-run reset clears set flags.
        drive(11'b11101000000);
        @(posedge clk);
        @(negedge clk);
        check("R2", 6'b111100);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", 6'b000000);
        rst_n = 1'b1;
        step(11'b11101000000, "R2", 6'b111100);

        // R8 tx DMA with a persistent condition: one cycle low, then back.
        step(11'b10110000000, "R6", 6'b110010);
        step(11'b10110000010, "R8", 6'b010000);
        step(11'b10110000000, "R8", 6'b110010);
        // R6 both channels in DMA at once.
        step(11'b11111100000, "R6", 6'b110011);
        step(11'b00000000000, "R10", 6'b110000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule